// File: doc/BRIEF.md
# Four-Cycle Bus Slot Arbiter

This block lets a CPU and a video fetch unit share one memory bus. A free-running phase counter splits time into four-clock periods. Each period holds one CPU window and one video window. The CPU may start a memory access only on its own slot boundary, so a request that arrives between boundaries waits for the next one. Video fetches follow a fixed cadence and never depend on CPU traffic.

Accesses to the slow peripheral window do not use the memory bus. They start on the next clock edge whatever the slot phase, and they are stretched by a ready input from the device. A strap input picks which half of the period belongs to the CPU, so the block supports both power-up phase relations between CPU and video.

An instruction's internal cycles cost time only when they move the next access off the grid. The time between two accesses is the instruction length rounded up to a multiple of four.

Top module: `slot_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first interval after it is released, cpu_ack_o, cpu_mem_o, dev_sel_o and vid_fetch_o are all low.
- R2: The phase counter is 0 after reset and advances by one each clock, modulo 4. The CPU boundary is phase 0 when phase_sel_i is 0 and phase 2 when it is 1. The strap is static and is changed only under reset.
- R3: vid_fetch_o is high for exactly one clock in every period, when the phase equals the CPU boundary plus 3 (modulo 4). This holds whether or not the CPU is requesting.
- R4: A memory request is first sampled at an edge whose phase is p. The access starts at the first edge at or after that one whose phase equals the CPU boundary b. cpu_ack_o is then high in the interval after the third following edge. The latency from raising the request to seeing the acknowledge is 4 + ((b - p) mod 4) clocks.
- R5: During a memory access, cpu_mem_o is high for the first two clocks after the start, and never in the same clock as vid_fetch_o. While cpu_mem_o is high, bus_addr_o and bus_we_o carry the address and write flag of the request.
- R6: cpu_ack_o is high for exactly one clock per access. It is low on the next clock once the request has been dropped.
- R7: A request that is high at the edge ending an acknowledge starts a new access if that edge is a boundary. A CPU that runs L clocks between the starts of successive accesses gets one access every ((L+3)/4)*4 clocks, with integer division.
- R8: A request whose address is at or above SLOW_BASE starts at the next edge whatever the phase. dev_sel_o is high for the whole access and cpu_mem_o stays low. cpu_ack_o rises once at least four clocks have passed and dev_rdy_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_sel_i | input | 1 | Strap that selects the CPU slot phase (0 or 2) |
| cpu_req_i | input | 1 | CPU access request, sampled at every edge |
| cpu_addr_i | input | AW | Address of the request |
| cpu_we_i | input | 1 | Write flag of the request |
| dev_rdy_i | input | 1 | Ready from the slow device |
| cpu_ack_o | output | 1 | One-clock acknowledge at the end of an access |
| vid_fetch_o | output | 1 | Video fetch strobe, once per period |
| cpu_mem_o | output | 1 | The CPU drives the memory bus |
| dev_sel_o | output | 1 | Slow device access in progress |
| bus_addr_o | output | AW | Latched access address |
| bus_we_o | output | 1 | Latched write flag |

## Verification
The bench builds the block with its defaults: a 4-clock period, a 16-bit address and the slow window at 0xC000 and above. It runs each test with both strap values. For every strap, it issues memory requests at all four phases of the counter and checks each latency against the rounding formula. It also runs back-to-back sequences with instruction lengths of 4 to 9 clocks, and slow accesses with 0 to 3 extra ready delays. This covers the whole space of alignment cases, because the period has only four phases.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int unsigned SLOT_LEN = 4;
  localparam int unsigned PH_W     = $clog2(SLOT_LEN);
  localparam int unsigned MEM_LEN  = SLOT_LEN / 2;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_MEM,
    ACC_DEV
  } acc_state_e;
endpackage

// File: rtl/slot_timer.sv
module slot_timer
  import slot_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_sel_i,
  output logic cpu_slot_o,
  output logic vid_fetch_o
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] cpu_ph;
  logic [PH_W-1:0] vid_ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + 1'b1;
  end

  // strap selects which half of the period is the CPU's
  assign cpu_ph = {phase_sel_i, {(PH_W-1){1'b0}}};
  assign vid_ph = cpu_ph + PH_W'(SLOT_LEN - 1);

  assign cpu_slot_o  = (phase_q == cpu_ph);
  assign vid_fetch_o = (phase_q == vid_ph);

  p_vid_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_fetch_o |=> !vid_fetch_o);
  p_slot_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_slot_o |=> !cpu_slot_o);
  p_strap_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(phase_sel_i));
endmodule

// File: rtl/access_ctl.sv
module access_ctl
  import slot_arb_pkg::*;
#(
  parameter int unsigned    AW        = 16,
  parameter logic [AW-1:0]  SLOW_BASE = 16'hC000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_slot_i,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          dev_rdy_i,
  output logic          ack_o,
  output logic          cpu_mem_o,
  output logic          dev_sel_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_we_o
);
  localparam logic [PH_W-1:0] LAST_CNT = PH_W'(SLOT_LEN - 1);
  localparam logic [PH_W-1:0] MEM_CNT  = PH_W'(MEM_LEN);

  acc_state_e      state_q;
  logic [PH_W-1:0] cnt_q;
  logic [AW-1:0]   addr_q;
  logic            we_q;

  logic is_dev, done, free, start_mem, start_dev;

  assign is_dev    = (addr_i >= SLOW_BASE);
  assign done      = (state_q != ACC_IDLE) && (cnt_q == LAST_CNT) &&
                     ((state_q == ACC_MEM) || dev_rdy_i);
  assign free      = (state_q == ACC_IDLE) || done;
  assign start_mem = free && req_i && !is_dev && cpu_slot_i;
  // slow device ignores the slot grid
  assign start_dev = free && req_i && is_dev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACC_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
    end else if (start_mem || start_dev) begin
      state_q <= start_mem ? ACC_MEM : ACC_DEV;
      cnt_q   <= '0;
      addr_q  <= addr_i;
      we_q    <= we_i;
    end else if (done) begin
      state_q <= ACC_IDLE;
      cnt_q   <= '0;
    end else if ((state_q != ACC_IDLE) && (cnt_q != LAST_CNT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ack_o      = done;
  assign cpu_mem_o  = (state_q == ACC_MEM) && (cnt_q < MEM_CNT);
  assign dev_sel_o  = (state_q == ACC_DEV);
  assign bus_addr_o = addr_q;
  assign bus_we_o   = we_q;

  p_ack_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_mem_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !dev_sel_o) |-> $past(cpu_slot_i, 4));
  p_mem_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_mem_o) |=> cpu_mem_o);
  p_dev_min_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_sel_o) |=> !ack_o);
endmodule

// File: rtl/slot_bus_arbiter.sv
module slot_bus_arbiter
  import slot_arb_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter logic [AW-1:0] SLOW_BASE = 16'hC000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phase_sel_i,
  input  logic          cpu_req_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic          cpu_we_i,
  input  logic          dev_rdy_i,
  output logic          cpu_ack_o,
  output logic          vid_fetch_o,
  output logic          cpu_mem_o,
  output logic          dev_sel_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_we_o
);
  logic cpu_slot;

  slot_timer u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_sel_i (phase_sel_i),
    .cpu_slot_o  (cpu_slot),
    .vid_fetch_o (vid_fetch_o)
  );

  access_ctl #(
    .AW        (AW),
    .SLOW_BASE (SLOW_BASE)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_slot_i (cpu_slot),
    .req_i      (cpu_req_i),
    .addr_i     (cpu_addr_i),
    .we_i       (cpu_we_i),
    .dev_rdy_i  (dev_rdy_i),
    .ack_o      (cpu_ack_o),
    .cpu_mem_o  (cpu_mem_o),
    .dev_sel_o  (dev_sel_o),
    .bus_addr_o (bus_addr_o),
    .bus_we_o   (bus_we_o)
  );

  p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_mem_o && vid_fetch_o));
  p_vid_after_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_fetch_o |-> !cpu_slot);
endmodule

// File: tb/slot_bus_arbiter_tb.sv
module slot_bus_arbiter_tb;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] SLOW_BASE = 16'hC000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic we = 1'b0;
  logic rdy = 1'b0;
  logic ack, vid, mem, dsel, bwe;
  logic [AW-1:0] baddr;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  slot_bus_arbiter #(.AW(AW), .SLOW_BASE(SLOW_BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .phase_sel_i(sel), .cpu_req_i(req),
    .cpu_addr_i(addr), .cpu_we_i(we), .dev_rdy_i(rdy), .cpu_ack_o(ack),
    .vid_fetch_o(vid), .cpu_mem_o(mem), .dev_sel_o(dsel),
    .bus_addr_o(baddr), .bus_we_o(bwe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int bnd();
    return sel ? 2 : 0;
  endfunction

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; rdy = 1'b0; sel = s;
    repeat (2) @(negedge clk);
    chk({ack, mem, dsel, vid} == 4'b0, "R1 outputs in reset", int'({ack, mem, dsel, vid}), 0);
    rst_n = 1'b1;
    #1;
    chk({ack, mem, dsel, vid} == 4'b0, "R1 outputs after release", int'({ack, mem, dsel, vid}), 0);
  endtask

  task automatic align(input int off);
    while ((cyc & 3) != off) tick();
  endtask

  // R4/R5/R6 single memory access from a given phase
  task automatic mem_access(input int off, input logic [AW-1:0] a, input logic w);
    int n = 0;
    int win = 0;
    int bad = 0;
    int exp_n;
    align(off);
    exp_n = 4 + ((bnd() - off) & 3);
    addr = a; we = w; req = 1'b1;
    do begin
      tick(); n++;
      if (mem) begin
        win++;
        if (baddr != a || bwe != w) bad++;
        if (vid) bad++;
      end
    end while (!ack && n < 40);
    req = 1'b0;
    chk(n == exp_n, "R4 latency", n, exp_n);
    chk(win == 2, "R5 cpu window length", win, 2);
    chk(bad == 0, "R5 bus address/overlap", bad, 0);
    tick();
    chk(ack == 1'b0, "R6 ack single clock", int'(ack), 0);
  endtask

  // R7 back-to-back with instruction length L
  task automatic run_seq(input int len, input int k);
    int t0 = 0;
    int t1 = 0;
    int g = len - 4;
    int exp_p = ((len + 3) / 4) * 4;
    addr = 16'h0100; we = 1'b0; req = 1'b1;
    for (int i = 0; i < k; i++) begin
      int guard = 0;
      do begin tick(); guard++; end while (!ack && guard < 40);
      if (i == 0) t0 = cyc;
      t1 = cyc;
      if (g > 0 && i < k - 1) begin
        req = 1'b0;
        repeat (g) tick();
        req = 1'b1;
      end
    end
    req = 1'b0;
    tick();
    chk((t1 - t0) == (k - 1) * exp_p, $sformatf("R7 period L=%0d", len), t1 - t0, (k - 1) * exp_p);
  endtask

  // R8 slow device access with w extra ready delays
  task automatic dev_access(input int off, input int w);
    int n = 0;
    int memhits = 0;
    int selmiss = 0;
    align(off);
    addr = SLOW_BASE + 16'h0010; we = 1'b1; rdy = 1'b0; req = 1'b1;
    do begin
      tick(); n++;
      if (n == 4 + w) rdy = 1'b1;
      #1;
      if (mem) memhits++;
      if (!dsel) selmiss++;
    end while (!ack && n < 40);
    req = 1'b0;
    tick();
    rdy = 1'b0;
    chk(n == 4 + w, "R8 slow latency", n, 4 + w);
    chk(memhits == 0, "R8 no memory window", memhits, 0);
    chk(selmiss == 0, "R8 device select held", selmiss, 0);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      int vbad = 0;
      do_reset(logic'(s));
      // R2/R3: strobe position, idle and with traffic
      for (int i = 0; i < 16; i++) begin
        if (vid != (((cyc & 3) == ((bnd() + 3) & 3)))) vbad++;
        tick();
      end
      chk(vbad == 0, "R3 video strobe idle (R2 phase)", vbad, 0);
      for (int off = 0; off < 4; off++)
        mem_access(off, AW'(16'h1230 + off), logic'(off & 1));
      vbad = 0;
      req = 1'b1; addr = 16'h0040;
      for (int i = 0; i < 16; i++) begin
        if (vid != (((cyc & 3) == ((bnd() + 3) & 3)))) vbad++;
        tick();
      end
      req = 1'b0;
      repeat (4) tick();
      chk(vbad == 0, "R3 video strobe under load", vbad, 0);
      for (int len = 4; len <= 9; len++) run_seq(len, 5);
      for (int w = 0; w < 4; w++) dev_access((w + s) & 3, w);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule